// File: doc/BRIEF.md
# Serial Management Slave for a 10/100 Transceiver

This block is the management end of a 10/100 Ethernet transceiver. A station manager reaches it over the two-wire serial management bus (clause-22 MDC/MDIO framing). Each frame carries a start pattern, a read or write opcode, a 5-bit device address, a 5-bit register number, a turnaround and 16 data bits. The block oversamples MDC and MDIO with its own system clock. It acts on each MDC rising edge, and it answers only frames that carry its own device address.

Behind the serial engine sits a small register set:
- a control word, whose fields leave the block as configuration outputs;
- a status word with fixed ability bits and latched link, fault and jabber bits;
- two identity words;
- an advertisement word;
- an interrupt status word and an interrupt enable word;
- a mode word that holds the device address and the preamble-suppression enable.

The block enters isolate mode at reset when the 5-bit address strap is zero. It drives an active-low interrupt line. Link, fault, jabber and interrupt events arrive as input pulses or levels from the rest of the transceiver.

Top module: `mdio_mgmt`

## Requirements
- R1: After reset, `mdio_oe` and `mdint_n` read 0 and 1. The control word holds 0x3000: speed bit 13 and auto-negotiation enable bit 12 are set. Bit 10 (isolate) is also set when the strap is zero. The mode word at address 20 holds the strap in bits 7:3 and has suppression enable bit 1 set.
- R2: After reset, a frame is answered only if at least 32 consecutive ones precede its start pattern 01. A frame with a shorter preamble gets no response.
- R3: Once one complete frame has passed, a later frame needs only one idle bit (a single 1) before its start pattern, provided mode bit 1 is set. When that bit is cleared, 32 ones are needed again. Status bit 6 mirrors mode bit 1.
- R4: A read frame uses opcode 10. In the first turnaround bit `mdio_oe` stays 0. In the second turnaround bit the block drives 0. It then drives the 16 data bits, MSB first, one per MDC edge, and releases MDIO after the last data bit.
- R5: The address in a frame is sent MSB first and compared with mode bits 7:3, which come from the strap. For a frame with any other address, MDIO stays undriven and writes (opcode 01) are discarded.
- R6: A zero strap at reset sets control bit 10 and `isolate_o`. Writing zero into mode bits 7:3 later leaves bit 10 clear.
- R7: Writing a 1 to control bit 15 restores every writable register to its reset value and gives a one-cycle `soft_reset_o` pulse. Writing a 1 to bit 9 gives a one-cycle `an_restart_o` pulse. Both bits always read 0. Of the remaining control bits, only 14, 13, 12, 11, 10, 8 and 7 are writable.
- R8: The status word reads as follows.
  - Bits 14:11, 3 and 0 always read 1. Bit 5 follows `an_complete`.
  - Bit 2 holds 0 once `link_ok` has been low, and it reads 0 after reset. A read of the word reloads it with the live `link_ok`.
  - Bits 4 (`rf_evt`) and 1 (`jab_evt`) hold 1 after a pulse until the word is read.
- R9: The identity words return the parameters `ID_HI` (address 2) and `ID_LO` (address 3). The advertisement word at address 4 resets to 0x05E1. Its bits 4:0 always read 00001, and only bits 13, 10 and 8:5 can be written.
- R10: Address 17 bits 6:0 latch pulses on `irq_evt[6:0]`. Reading address 17 clears them. `mdint_n` goes low while any latched bit has its enable set in address 18, bits 6:0.
- R11: Addresses other than 0, 1, 2, 3, 4, 17, 18 and 20 read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the management bus |
| rst | input | 1 | Synchronous active-high hardware reset; the strap is sampled while it is high |
| strap_addr | input | 5 | Device address strap |
| mdc | input | 1 | Management clock from the station manager |
| mdio_i | input | 1 | Management data received from the bus |
| mdio_o | output | 1 | Management data driven onto the bus |
| mdio_oe | output | 1 | Drive enable for `mdio_o` |
| link_ok | input | 1 | Live link state |
| an_complete | input | 1 | Live auto-negotiation completion |
| rf_evt | input | 1 | Remote fault event pulse |
| jab_evt | input | 1 | Jabber event pulse |
| irq_evt | input | 7 | Interrupt source event pulses |
| mdint_n | output | 1 | Active-low interrupt |
| soft_reset_o | output | 1 | One-cycle pulse on a software reset |
| an_restart_o | output | 1 | One-cycle pulse on an auto-negotiation restart |
| isolate_o | output | 1 | Control bit 10 |
| loopback_o | output | 1 | Control bit 14 |
| speed100_o | output | 1 | Control bit 13 |
| an_enable_o | output | 1 | Control bit 12 |
| power_down_o | output | 1 | Control bit 11 |
| full_duplex_o | output | 1 | Control bit 8 |
| col_test_o | output | 1 | Control bit 7 |

## Verification
The bench holds MDC high and low for six system clocks each. MDC and MDIO pass two synchronizer stages and an edge register, so the response to a rising edge appears on `mdio_o`/`mdio_oe` three clocks after that edge. The bench samples the bus just before it drops MDC, so it reads the bit the block will present at the next rising edge. Register side effects and the configuration outputs settle within the same three clocks, and `mdint_n` settles two clocks after an event pulse. The bench therefore reads these outputs only after a full frame or after a four-clock wait.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  typedef enum logic [2:0] {
    S_HUNT,
    S_START,
    S_HDR,
    S_TA,
    S_DATA
  } frame_st_t;

  localparam logic [4:0] A_CTRL = 5'd0;
  localparam logic [4:0] A_STAT = 5'd1;
  localparam logic [4:0] A_ID_H = 5'd2;
  localparam logic [4:0] A_ID_L = 5'd3;
  localparam logic [4:0] A_ADV  = 5'd4;
  localparam logic [4:0] A_IRQ  = 5'd17;
  localparam logic [4:0] A_IEN  = 5'd18;
  localparam logic [4:0] A_MODE = 5'd20;

  localparam logic [1:0] OP_RD = 2'b10;
  localparam logic [1:0] OP_WR = 2'b01;

  localparam logic [15:0] CTRL_WMASK = 16'h7D80;
  localparam logic [15:0] ADV_WMASK  = 16'h25E0;
  localparam logic [15:0] ADV_RESET  = 16'h05E1;
  localparam logic [15:0] MODE_WMASK = 16'h00FA;
  localparam logic [15:0] STAT_FIXED = 16'h7809;
endpackage

// File: rtl/mdio_sync.sv
module mdio_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) chain[0] <= d;

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) chain[s] <= chain[s-1];
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
  import mdio_pkg::*;
#(
  parameter int PREAMBLE_LEN = 32
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        mdc_s,
  input  logic        mdio_s,
  input  logic [4:0]  my_addr,
  input  logic        supp_en,
  input  logic [15:0] rd_data,
  output logic [4:0]  reg_addr,
  output logic        rd_fire,
  output logic        wr_fire,
  output logic [15:0] wr_data,
  output logic        mdio_o,
  output logic        mdio_oe
);
  localparam int PW = $clog2(PREAMBLE_LEN + 1);
  localparam logic [PW-1:0] PRE_MAX = PW'(PREAMBLE_LEN);
  localparam int HDR_BITS = 12;
  localparam logic [4:0] HDR_LAST = 5'(HDR_BITS - 1);
  localparam logic [4:0] DATA_LAST = 5'd15;

  frame_st_t state;
  logic [PW-1:0] pre_cnt;
  logic [4:0]    cnt;
  logic [HDR_BITS-1:0] hdr;
  logic [15:0]   sr;
  logic          mdc_q, first_done, is_rd, is_wr;
  logic          rise;
  logic [HDR_BITS-1:0] hdr_n;
  logic          match;

  assign rise  = mdc_s & ~mdc_q;
  assign hdr_n = {hdr[HDR_BITS-2:0], mdio_s};
  assign match = (hdr_n[9:5] == my_addr);

  assign rd_fire = rise && (state == S_TA) && (cnt == 5'd0) && is_rd;
  assign wr_fire = rise && (state == S_DATA) && (cnt == DATA_LAST) && is_wr;
  assign wr_data = {sr[14:0], mdio_s};

  always_ff @(posedge clk) begin
    if (rst) begin
      mdc_q      <= 1'b0;
      state      <= S_HUNT;
      pre_cnt    <= '0;
      cnt        <= '0;
      hdr        <= '0;
      sr         <= '0;
      first_done <= 1'b0;
      is_rd      <= 1'b0;
      is_wr      <= 1'b0;
      reg_addr   <= '0;
      mdio_o     <= 1'b0;
      mdio_oe    <= 1'b0;
    end else begin
      mdc_q <= mdc_s;
      if (rise) begin
        unique case (state)
          S_HUNT: begin
            if (mdio_s) begin
              if (pre_cnt != PRE_MAX) pre_cnt <= pre_cnt + 1'b1;
            end else begin
              if (pre_cnt == PRE_MAX || (first_done && supp_en && pre_cnt != '0))
                state <= S_START;
              pre_cnt <= '0;
            end
          end
          S_START: begin
            cnt   <= '0;
            state <= mdio_s ? S_HDR : S_HUNT;
          end
          S_HDR: begin
            hdr <= hdr_n;
            cnt <= cnt + 1'b1;
            if (cnt == HDR_LAST) begin
              reg_addr <= hdr_n[4:0];
              is_rd    <= match && (hdr_n[11:10] == OP_RD);
              is_wr    <= match && (hdr_n[11:10] == OP_WR);
              cnt      <= '0;
              state    <= S_TA;
            end
          end
          S_TA: begin
            if (cnt == 5'd0) begin
              cnt <= 5'd1;
              if (is_rd) begin
                mdio_oe <= 1'b1;
                mdio_o  <= 1'b0;
                sr      <= rd_data;
              end
            end else begin
              cnt   <= '0;
              state <= S_DATA;
              if (is_rd) begin
                mdio_o <= sr[15];
                sr     <= {sr[14:0], 1'b0};
              end
            end
          end
          S_DATA: begin
            cnt <= cnt + 1'b1;
            if (is_rd) begin
              mdio_o <= sr[15];
              sr     <= {sr[14:0], 1'b0};
            end else begin
              sr <= {sr[14:0], mdio_s};
            end
            if (cnt == DATA_LAST) begin
              mdio_oe    <= 1'b0;
              mdio_o     <= 1'b0;
              state      <= S_HUNT;
              pre_cnt    <= '0;
              first_done <= 1'b1;
              is_rd      <= 1'b0;
              is_wr      <= 1'b0;
            end
          end
          default: state <= S_HUNT;
        endcase
      end
    end
  end

  // R4
  ta_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mdio_oe) |-> !mdio_o);

  // R5
  oe_match_chk: assert property (@(posedge clk) disable iff (rst)
    mdio_oe |-> is_rd);

  // R5
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(is_rd && is_wr));
endmodule

// File: rtl/mgmt_regs.sv
module mgmt_regs
  import mdio_pkg::*;
#(
  parameter logic [15:0] ID_HI    = 16'h2C71,
  parameter logic [15:0] ID_LO    = 16'h5E12,
  parameter int          IRQ_BITS = 7
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [4:0]          strap_addr,
  input  logic                rd_fire,
  input  logic                wr_fire,
  input  logic [4:0]          addr,
  input  logic [15:0]         wr_data,
  input  logic                link_ok,
  input  logic                an_complete,
  input  logic                rf_evt,
  input  logic                jab_evt,
  input  logic [IRQ_BITS-1:0] irq_evt,
  output logic [15:0]         rd_data,
  output logic [4:0]          phy_addr,
  output logic                supp_en,
  output logic                mdint_n,
  output logic                soft_reset_o,
  output logic                an_restart_o,
  output logic                isolate_o,
  output logic                loopback_o,
  output logic                speed100_o,
  output logic                an_enable_o,
  output logic                power_down_o,
  output logic                full_duplex_o,
  output logic                col_test_o
);
  localparam int PAD = 16 - IRQ_BITS;

  logic [15:0]         ctrl_q, adv_q, mode_q;
  logic [IRQ_BITS-1:0] ien_q, irq_lat;
  logic [4:0]          strap_q;
  logic                link_lat, rf_lat, jab_lat;
  logic                rd_stat, rd_irq;

  function automatic logic [15:0] ctrl_reset(input logic [4:0] s);
    return 16'h3000 | ((s == 5'd0) ? 16'h0400 : 16'h0000);
  endfunction

  function automatic logic [15:0] mode_reset(input logic [4:0] s);
    return {8'h00, s, 3'b010};
  endfunction

  assign rd_stat = rd_fire && (addr == A_STAT);
  assign rd_irq  = rd_fire && (addr == A_IRQ);

  always_ff @(posedge clk) begin
    soft_reset_o <= 1'b0;
    an_restart_o <= 1'b0;
    if (rst) begin
      strap_q <= strap_addr;
      ctrl_q  <= ctrl_reset(strap_addr);
      adv_q   <= ADV_RESET;
      ien_q   <= '0;
      mode_q  <= mode_reset(strap_addr);
    end else if (wr_fire && addr == A_CTRL && wr_data[15]) begin
      ctrl_q       <= ctrl_reset(strap_q);
      adv_q        <= ADV_RESET;
      ien_q        <= '0;
      mode_q       <= mode_reset(strap_q);
      soft_reset_o <= 1'b1;
    end else if (wr_fire) begin
      unique case (addr)
        A_CTRL: begin
          ctrl_q       <= wr_data & CTRL_WMASK;
          an_restart_o <= wr_data[9];
        end
        A_ADV:  adv_q  <= (wr_data & ADV_WMASK) | (ADV_RESET & ~ADV_WMASK);
        A_IEN:  ien_q  <= wr_data[IRQ_BITS-1:0];
        A_MODE: mode_q <= wr_data & MODE_WMASK;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      link_lat <= 1'b0;
      rf_lat   <= 1'b0;
      jab_lat  <= 1'b0;
      irq_lat  <= '0;
      mdint_n  <= 1'b1;
    end else begin
      link_lat <= rd_stat ? link_ok : (link_lat & link_ok);
      rf_lat   <= (rd_stat ? 1'b0 : rf_lat) | rf_evt;
      jab_lat  <= (rd_stat ? 1'b0 : jab_lat) | jab_evt;
      irq_lat  <= (rd_irq ? '0 : irq_lat) | irq_evt;
      mdint_n  <= ~|(irq_lat & ien_q);
    end
  end

  always_comb begin
    unique case (addr)
      A_CTRL: rd_data = ctrl_q;
      A_STAT: rd_data = STAT_FIXED | {9'd0, mode_q[1], an_complete, rf_lat,
                                       1'b0, link_lat, jab_lat, 1'b0};
      A_ID_H: rd_data = ID_HI;
      A_ID_L: rd_data = ID_LO;
      A_ADV:  rd_data = adv_q;
      A_IRQ:  rd_data = {{PAD{1'b0}}, irq_lat};
      A_IEN:  rd_data = {{PAD{1'b0}}, ien_q};
      A_MODE: rd_data = mode_q;
      default: rd_data = 16'h0000;
    endcase
  end

  assign phy_addr      = mode_q[7:3];
  assign supp_en       = mode_q[1];
  assign isolate_o     = ctrl_q[10];
  assign loopback_o    = ctrl_q[14];
  assign speed100_o    = ctrl_q[13];
  assign an_enable_o   = ctrl_q[12];
  assign power_down_o  = ctrl_q[11];
  assign full_duplex_o = ctrl_q[8];
  assign col_test_o    = ctrl_q[7];

  // R8
  link_low_chk: assert property (@(posedge clk) disable iff (rst)
    (!link_ok && !rd_stat) |=> !link_lat);

  // R10
  irq_clr_chk: assert property (@(posedge clk) disable iff (rst)
    rd_irq |=> ((irq_lat & ~$past(irq_evt)) == '0));

  // R7
  restart_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    an_restart_o |=> !an_restart_o);

  // R7
  soft_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    soft_reset_o |-> (ctrl_q[14] == 1'b0 && adv_q == ADV_RESET));
endmodule

// File: rtl/mdio_mgmt.sv
module mdio_mgmt #(
  parameter logic [15:0] ID_HI        = 16'h2C71,
  parameter logic [15:0] ID_LO        = 16'h5E12,
  parameter int          PREAMBLE_LEN = 32,
  parameter int          SYNC_STAGES  = 2,
  parameter int          IRQ_BITS     = 7
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [4:0]          strap_addr,
  input  logic                mdc,
  input  logic                mdio_i,
  output logic                mdio_o,
  output logic                mdio_oe,
  input  logic                link_ok,
  input  logic                an_complete,
  input  logic                rf_evt,
  input  logic                jab_evt,
  input  logic [IRQ_BITS-1:0] irq_evt,
  output logic                mdint_n,
  output logic                soft_reset_o,
  output logic                an_restart_o,
  output logic                isolate_o,
  output logic                loopback_o,
  output logic                speed100_o,
  output logic                an_enable_o,
  output logic                power_down_o,
  output logic                full_duplex_o,
  output logic                col_test_o
);
  logic [1:0]  bus_s;
  logic [4:0]  reg_addr, phy_addr;
  logic        rd_fire, wr_fire, supp_en;
  logic [15:0] wr_data, rd_data;

  mdio_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .d   ({mdc, mdio_i}),
    .q   (bus_s)
  );

  mdio_frame #(.PREAMBLE_LEN(PREAMBLE_LEN)) u_frame (
    .clk      (clk),
    .rst      (rst),
    .mdc_s    (bus_s[1]),
    .mdio_s   (bus_s[0]),
    .my_addr  (phy_addr),
    .supp_en  (supp_en),
    .rd_data  (rd_data),
    .reg_addr (reg_addr),
    .rd_fire  (rd_fire),
    .wr_fire  (wr_fire),
    .wr_data  (wr_data),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe)
  );

  mgmt_regs #(.ID_HI(ID_HI), .ID_LO(ID_LO), .IRQ_BITS(IRQ_BITS)) u_regs (
    .clk           (clk),
    .rst           (rst),
    .strap_addr    (strap_addr),
    .rd_fire       (rd_fire),
    .wr_fire       (wr_fire),
    .addr          (reg_addr),
    .wr_data       (wr_data),
    .link_ok       (link_ok),
    .an_complete   (an_complete),
    .rf_evt        (rf_evt),
    .jab_evt       (jab_evt),
    .irq_evt       (irq_evt),
    .rd_data       (rd_data),
    .phy_addr      (phy_addr),
    .supp_en       (supp_en),
    .mdint_n       (mdint_n),
    .soft_reset_o  (soft_reset_o),
    .an_restart_o  (an_restart_o),
    .isolate_o     (isolate_o),
    .loopback_o    (loopback_o),
    .speed100_o    (speed100_o),
    .an_enable_o   (an_enable_o),
    .power_down_o  (power_down_o),
    .full_duplex_o (full_duplex_o),
    .col_test_o    (col_test_o)
  );
endmodule

// File: tb/sim_mdio_mgmt.sv
`timescale 1ns/1ps
module sim_mdio_mgmt;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [4:0] strap_addr = 5'h0B;
  logic mdc = 1'b0, mdio_i = 1'b1;
  logic mdio_o, mdio_oe;
  logic link_ok = 1'b1, an_complete = 1'b0, rf_evt = 1'b0, jab_evt = 1'b0;
  logic [6:0] irq_evt = '0;
  logic mdint_n, soft_reset_o, an_restart_o, isolate_o, loopback_o;
  logic speed100_o, an_enable_o, power_down_o, full_duplex_o, col_test_o;

  int vectors = 0, miscompares = 0;
  int soft_cnt = 0, restart_cnt = 0;
  bit done = 0;

  always #5 clk = ~clk;

  mdio_mgmt u0 (
    .clk(clk), .rst(rst), .strap_addr(strap_addr), .mdc(mdc), .mdio_i(mdio_i),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .link_ok(link_ok), .an_complete(an_complete),
    .rf_evt(rf_evt), .jab_evt(jab_evt), .irq_evt(irq_evt), .mdint_n(mdint_n),
    .soft_reset_o(soft_reset_o), .an_restart_o(an_restart_o), .isolate_o(isolate_o),
    .loopback_o(loopback_o), .speed100_o(speed100_o), .an_enable_o(an_enable_o),
    .power_down_o(power_down_o), .full_duplex_o(full_duplex_o), .col_test_o(col_test_o)
  );

  always @(posedge clk) begin
    if (soft_reset_o) soft_cnt <= soft_cnt + 1;
    if (an_restart_o) restart_cnt <= restart_cnt + 1;
  end

  function automatic logic [15:0] exp_status(input logic mfps, input logic an,
      input logic rf, input logic lnk, input logic jab);
    return 16'h7809 | {9'd0, mfps, an, rf, 1'b0, lnk, jab, 1'b0};
  endfunction

  function automatic bit implemented(input logic [4:0] a);
    return a inside {5'd0, 5'd1, 5'd2, 5'd3, 5'd4, 5'd17, 5'd18, 5'd20};
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b, output logic so, output logic soe);
    mdio_i = b;
    tick(3);
    mdc = 1'b1;
    tick(6);
    so  = mdio_o;
    soe = mdio_oe;
    mdc = 1'b0;
    tick(3);
  endtask

  // one frame; rd selects opcode 10, else 01
  task automatic frame(input int pre, input bit rd, input logic [4:0] phy,
      input logic [4:0] ra, input logic [15:0] wd,
      output logic [15:0] rdata, output bit good, output bit any_oe);
    logic so, soe;
    logic [15:0] hdr;
    good = 1; any_oe = 0; rdata = '0;
    for (int i = 0; i < pre; i++) begin send_bit(1'b1, so, soe); any_oe |= soe; end
    hdr = {2'b01, rd ? 2'b10 : 2'b01, phy, ra, 2'b00};
    for (int i = 15; i >= 2; i--) begin send_bit(hdr[i], so, soe); any_oe |= soe; end
    if (soe) good = 0;
    send_bit(1'b1, so, soe); any_oe |= soe;
    if (!(soe && !so)) good = 0;
    send_bit(rd ? 1'b1 : 1'b0, so, soe); any_oe |= soe;
    if (!soe) good = 0;
    rdata[15] = so;
    for (int k = 0; k < 16; k++) begin
      send_bit(rd ? 1'b1 : wd[15-k], so, soe); any_oe |= (soe && k != 15);
      if (k < 15) begin rdata[14-k] = so; if (!soe) good = 0; end
      else if (soe) good = 0;
    end
  endtask

  task automatic rd_reg(input string tag, input int pre, input logic [4:0] phy,
      input logic [4:0] ra, input logic [15:0] exp);
    logic [15:0] d; bit g, a;
    frame(pre, 1, phy, ra, 16'h0, d, g, a);
    check({tag, " read framing"}, {15'd0, g}, 16'd1);
    check({tag, " read data"}, d, exp);
  endtask

  task automatic rd_none(input string tag, input int pre, input logic [4:0] phy,
      input logic [4:0] ra);
    logic [15:0] d; bit g, a;
    frame(pre, 1, phy, ra, 16'h0, d, g, a);
    check({tag, " bus left undriven"}, {15'd0, a}, 16'd0);
  endtask

  task automatic wr_reg(input int pre, input logic [4:0] phy, input logic [4:0] ra,
      input logic [15:0] wd);
    logic [15:0] d; bit g, a;
    frame(pre, 0, phy, ra, wd, d, g, a);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog actual=running expected=finished");
    report();
  end

  initial begin
    logic [15:0] ctrl_m, adv_m, ien_m, mode_m, exp;
    logic [4:0] ra, phy;
    int rc;
    void'($urandom(32'd5417));
    tick(4);
    rst = 1'b0;
    tick(2);
    // R1 reset state
    check("R1 mdio_oe", {15'd0, mdio_oe}, 16'd0);
    check("R1 mdint_n", {15'd0, mdint_n}, 16'd1);
    check("R1 config outs", {11'd0, speed100_o, an_enable_o, isolate_o, loopback_o, power_down_o},
          16'b11000);
    // R2 short preamble before first frame is ignored
    rd_none("R2 short preamble", 20, 5'h0B, 5'd0);
    rd_reg("R2 R1 ctrl", 32, 5'h0B, 5'd0, 16'h3000);
    // R3 suppressed preamble accepted after first frame
    rd_reg("R3 R1 mode", 1, 5'h0B, 5'd20, 16'h005A);
    // R9 fixed words
    rd_reg("R9 id hi", 1, 5'h0B, 5'd2, 16'h2C71);
    rd_reg("R9 id lo", 1, 5'h0B, 5'd3, 16'h5E12);
    rd_reg("R9 adv", 1, 5'h0B, 5'd4, 16'h05E1);
    // R8 link latch low
    rd_reg("R8 status first", 1, 5'h0B, 5'd1, exp_status(1, 0, 0, 0, 0));
    rd_reg("R8 status live", 1, 5'h0B, 5'd1, exp_status(1, 0, 0, 1, 0));
    link_ok = 1'b0; tick(5); link_ok = 1'b1; tick(2);
    rd_reg("R8 link latched low", 1, 5'h0B, 5'd1, exp_status(1, 0, 0, 0, 0));
    rd_reg("R8 link reloaded", 1, 5'h0B, 5'd1, exp_status(1, 0, 0, 1, 0));
    rf_evt = 1'b1; jab_evt = 1'b1; tick(1); rf_evt = 1'b0; jab_evt = 1'b0;
    an_complete = 1'b1;
    rd_reg("R8 fault jabber latched", 1, 5'h0B, 5'd1, exp_status(1, 1, 1, 1, 1));
    rd_reg("R8 fault jabber cleared", 1, 5'h0B, 5'd1, exp_status(1, 1, 0, 1, 0));
    an_complete = 1'b0;
    // R5 address mismatch
    rd_none("R5 other address", 1, 5'h0C, 5'd0);
    wr_reg(1, 5'h1B, 5'd0, 16'h4000);
    rd_reg("R5 write to other address", 1, 5'h0B, 5'd0, 16'h3000);
    check("R5 loopback_o", {15'd0, loopback_o}, 16'd0);
    wr_reg(1, 5'h0B, 5'd20, 16'h00AA);
    rd_none("R5 old address", 1, 5'h0B, 5'd20);
    rd_reg("R5 new address", 1, 5'h15, 5'd20, 16'h00AA);
    // R6 zero written later: no isolation
    wr_reg(1, 5'h15, 5'd20, 16'h0002);
    rd_reg("R6 ctrl after zero addr", 1, 5'h00, 5'd0, 16'h3000);
    check("R6 isolate_o", {15'd0, isolate_o}, 16'd0);
    wr_reg(1, 5'h00, 5'd20, 16'h005A);
    // R3 suppression disabled
    wr_reg(1, 5'h0B, 5'd20, 16'h0058);
    rd_none("R3 suppression off", 1, 5'h0B, 5'd20);
    rd_reg("R3 status mirror", 32, 5'h0B, 5'd1, exp_status(0, 0, 0, 1, 0));
    wr_reg(32, 5'h0B, 5'd20, 16'h005A);
    // R7 self clearing bits
    rc = restart_cnt;
    wr_reg(1, 5'h0B, 5'd0, 16'h7F80);
    check("R7 restart pulse", 16'(restart_cnt - rc), 16'd1);
    rd_reg("R7 ctrl after restart", 1, 5'h0B, 5'd0, 16'h7D80);
    check("R7 outs", {9'd0, loopback_o, speed100_o, an_enable_o, power_down_o, isolate_o,
          full_duplex_o, col_test_o}, 16'h007F);
    wr_reg(1, 5'h0B, 5'd4, 16'hFFFF);
    rd_reg("R9 adv write mask", 1, 5'h0B, 5'd4, 16'h25E1);
    wr_reg(1, 5'h0B, 5'd0, 16'h8000);
    check("R7 soft pulse", 16'(soft_cnt), 16'd1);
    rd_reg("R7 ctrl defaults", 1, 5'h0B, 5'd0, 16'h3000);
    rd_reg("R7 adv defaults", 1, 5'h0B, 5'd4, 16'h05E1);
    // R10 interrupts
    wr_reg(1, 5'h0B, 5'd18, 16'h0005);
    irq_evt = 7'h02; tick(1); irq_evt = '0; tick(4);
    check("R10 masked event", {15'd0, mdint_n}, 16'd1);
    irq_evt = 7'h04; tick(1); irq_evt = '0; tick(4);
    check("R10 enabled event", {15'd0, mdint_n}, 16'd0);
    rd_reg("R10 irq status", 1, 5'h0B, 5'd17, 16'h0006);
    tick(4);
    check("R10 cleared by read", {15'd0, mdint_n}, 16'd1);
    rd_reg("R10 irq empty", 1, 5'h0B, 5'd17, 16'h0000);
    // R11 unimplemented
    rd_reg("R11 addr 5", 1, 5'h0B, 5'd5, 16'h0000);
    wr_reg(1, 5'h0B, 5'd7, 16'hFFFF);
    rd_reg("R11 addr 7", 1, 5'h0B, 5'd7, 16'h0000);
    // random mix: R4 R9 R11
    ctrl_m = 16'h3000; adv_m = 16'h05E1; ien_m = 16'h0005; mode_m = 16'h005A;
    for (int n = 0; n < 36; n++) begin
      ra = 5'($urandom_range(0, 31));
      if (ra == 5'd1 || ra == 5'd17) ra = 5'd4;
      phy = mode_m[7:3];
      if ($urandom_range(0, 1) == 1) begin
        exp = 16'($urandom());
        if (ra == 5'd0) exp[15] = 1'b0;
        wr_reg(32, phy, ra, exp);
        rc = restart_cnt;
        case (ra)
          5'd0:  ctrl_m = exp & 16'h7D80;
          5'd4:  adv_m  = 16'h0001 | (exp & 16'h25E0);
          5'd18: ien_m  = exp & 16'h007F;
          5'd20: mode_m = exp & 16'h00FA;
          default: ;
        endcase
      end else begin
        case (ra)
          5'd0:  exp = ctrl_m;
          5'd2:  exp = 16'h2C71;
          5'd3:  exp = 16'h5E12;
          5'd4:  exp = adv_m;
          5'd18: exp = ien_m;
          5'd20: exp = mode_m;
          default: exp = 16'h0000;
        endcase
        rd_reg(implemented(ra) ? "R4 R9 random read" : "R11 random read", 32, phy, ra, exp);
      end
    end
    // R6 zero strap isolates at reset
    strap_addr = 5'h00;
    rst = 1'b1; tick(4); rst = 1'b0; tick(2);
    check("R6 isolate_o at reset", {15'd0, isolate_o}, 16'd1);
    rd_reg("R6 R1 ctrl isolate", 32, 5'h00, 5'd0, 16'h3400);
    report();
  end
endmodule